// File: doc/BRIEF.md
# Extended-Address Call and Interrupt Stack Framer

This block builds and unpacks stack frames for a processor whose program counter and addresses are 20 bits wide but whose memory data path is only 16 bits. It serves six operations: short call, long call, interrupt entry, short return, long return and interrupt return. The decode logic issues a one-cycle request with the operation code, the current 20-bit program counter, the low status bits and, for interrupt entry, the 16-bit vector. The block then owns the stack pointer and drives one memory word access per clock cycle. When it is finished it reports the restored program counter and status word.

A long call uses two full stack words for its return address, and 12 bits of one of them are wasted. The interrupt frame also uses two words, but it is denser. The four upper program-counter bits go into the upper bits of the saved status word, which the status register does not use. On interrupt return, those bits come back out of that word, and they are cleared in the live status value. Interrupt handlers are entered through a 16-bit vector, so their address lies in the lowest 64 KB. The interrupted program can still resume anywhere in the 20-bit space. The stack grows downward in 2-byte steps. The memory is a single-cycle word port with a combinational read.

The controller is a state machine with six states. ST_IDLE waits for a request. ST_PUSH_A writes the first word of a two-word frame. ST_PUSH_B writes the last pushed word. ST_POP_A reads the first word. ST_POP_B reads the second word. ST_FIN signals completion. The transitions are:
- ST_IDLE goes to ST_PUSH_B on a short call, to ST_PUSH_A on a long call or interrupt entry, and to ST_POP_A on any return.
- ST_PUSH_A goes to ST_PUSH_B.
- ST_PUSH_B goes to ST_FIN.
- ST_POP_A goes to ST_FIN on a short return and to ST_POP_B otherwise.
- ST_POP_B goes to ST_FIN.
- ST_FIN goes to ST_IDLE.

Top module: `xstack_ctrl`

## Requirements
- R1: After reset, sp_out equals the parameter SP_RESET (default 0x00400), and busy, done, mem_en, pc_out and sr_out are all zero.
- R2: A request is accepted only when the block is idle, req_valid is high and req_kind is a legal code: 0 short call, 1 long call, 2 interrupt entry, 3 short return, 4 long return, 5 interrupt return. Codes 6 and 7 are ignored, and so is any request made while busy. An ignored request does not touch memory or sp_out. The inputs pc_in, sr_in and vec_in are sampled only at acceptance.
- R3: Each stack access takes one cycle. A push writes at sp_out−2 and leaves sp_out at that address. A pop reads at sp_out and then adds 2. For an N-word frame, busy is high from the cycle after acceptance, and done is high in cycle N+1 after acceptance.
- R4: A short call writes one word, pc_in[15:0], at sp−2.
- R5: A long call writes {12'b0, pc_in[19:16]} at sp−2, then pc_in[15:0] at sp−4.
- R6: An interrupt entry writes pc_in[15:0] at sp−2, then the packed word {pc_in[19:16], sr_in[11:0]} at sp−4. When done is high, pc_out is {4'h0, vec_in}.
- R7: A short return reads one word W and sets pc_out to {4'h0, W}.
- R8: A long return reads the low word L at sp and the high word H at sp+2, and sets pc_out to {H[3:0], L}. Bits H[15:4] have no effect.
- R9: An interrupt return reads the packed word P at sp and the low word L at sp+2. It sets pc_out to {P[15:12], L} and sr_out to {4'h0, P[11:0]}.
- R10: Calls leave pc_out unchanged. Only interrupt return changes sr_out.
- R11: done is a one-cycle pulse while busy is high, and busy is low in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 3 | Operation code (see R2) |
| pc_in | input | 20 | Program counter to save |
| sr_in | input | 12 | Savable low status bits |
| vec_in | input | 16 | Interrupt vector for entry |
| busy | output | 1 | Frame sequence in progress |
| done | output | 1 | Completion pulse |
| pc_out | output | 20 | Restored or vectored program counter |
| sr_out | output | 16 | Restored status word |
| sp_out | output | 20 | Stack pointer |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 20 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid in the same cycle |

## Verification
A wrong state or a bad transition changes the number of memory accesses. It therefore shows up in the same cycle as a missing or extra access, and as a done pulse that arrives early or late against the expected word count. A stack pointer off by one step puts every later frame at the wrong address. Because every return draws from a memory image predicted in the bench, a stale held word or a packing error is visible in pc_out or sr_out on the very done pulse that ends the return. Random sequences of calls and returns are mixed with directed cases: round trips with nonzero upper address bits, wasted high bits planted with garbage, illegal codes, and requests made while busy.

// File: rtl/xstack_pkg.sv
package xstack_pkg;

    typedef enum logic [2:0] {
        K_SCALL  = 3'd0,
        K_LCALL  = 3'd1,
        K_IENTER = 3'd2,
        K_SRET   = 3'd3,
        K_LRET   = 3'd4,
        K_IRET   = 3'd5
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_A,
        ST_PUSH_B,
        ST_POP_A,
        ST_POP_B,
        ST_FIN
    } state_e;

endpackage

// File: rtl/xstack_sp.sv
module xstack_sp #(
    parameter int          ADDR_W    = 20,
    parameter logic [19:0] RESET_VAL = 20'h00400,
    parameter int          STEP      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    output logic [ADDR_W-1:0] sp,
    output logic [ADDR_W-1:0] sp_dn
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    assign sp_dn = sp - STEP_V;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sp <= ADDR_W'(RESET_VAL);
        else if (push) sp <= sp_dn;
        else if (pop)  sp <= sp + STEP_V;
    end
endmodule

// File: rtl/xstack_frame.sv
module xstack_frame
    import xstack_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    localparam int HI_W  = ADDR_W - DATA_W,
    localparam int SR_W  = DATA_W - HI_W
) (
    input  kind_e             kind,
    input  logic [ADDR_W-1:0] pc_save,
    input  logic [SR_W-1:0]   sr_save,
    input  logic [DATA_W-1:0] held,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] word_a,
    output logic [DATA_W-1:0] word_b,
    output logic [ADDR_W-1:0] pc_one,
    output logic [ADDR_W-1:0] pc_two,
    output logic [DATA_W-1:0] sr_two
);
    logic [DATA_W-1:0] hi_word;
    logic [DATA_W-1:0] packed_sr;

    assign hi_word   = {{SR_W{1'b0}}, pc_save[ADDR_W-1:DATA_W]};
    assign packed_sr = {pc_save[ADDR_W-1:DATA_W], sr_save};

    always_comb begin
        word_a = pc_save[DATA_W-1:0];
        word_b = pc_save[DATA_W-1:0];
        if (kind == K_LCALL)  word_a = hi_word;
        if (kind == K_IENTER) word_b = packed_sr;
    end

    assign pc_one = {{HI_W{1'b0}}, rdata};
    assign pc_two = (kind == K_IRET) ? {held[DATA_W-1 -: HI_W], rdata}
                                     : {rdata[HI_W-1:0], held};
    assign sr_two = {{HI_W{1'b0}}, held[SR_W-1:0]};
endmodule

// File: rtl/xstack_ctrl.sv
module xstack_ctrl
    import xstack_pkg::*;
#(
    parameter int          ADDR_W   = 20,
    parameter int          DATA_W   = 16,
    parameter logic [19:0] SP_RESET = 20'h00400,
    localparam int         HI_W     = ADDR_W - DATA_W,
    localparam int         SR_W     = DATA_W - HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [SR_W-1:0]   sr_in,
    input  logic [DATA_W-1:0] vec_in,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] pc_out,
    output logic [DATA_W-1:0] sr_out,
    output logic [ADDR_W-1:0] sp_out,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int STEP = DATA_W / 8;

    state_e            state_q, state_d;
    kind_e             kind_q;
    logic [ADDR_W-1:0] pc_q;
    logic [SR_W-1:0]   sr_q;
    logic [DATA_W-1:0] vec_q;
    logic [DATA_W-1:0] held_q;
    logic              accept;
    logic              do_push, do_pop;
    logic [ADDR_W-1:0] sp_dn;
    logic [DATA_W-1:0] word_a, word_b, sr_two;
    logic [ADDR_W-1:0] pc_one, pc_two;

    assign accept  = (state_q == ST_IDLE) && req_valid && (req_kind <= K_IRET);
    assign do_push = (state_q == ST_PUSH_A) || (state_q == ST_PUSH_B);
    assign do_pop  = (state_q == ST_POP_A)  || (state_q == ST_POP_B);

    xstack_sp #(.ADDR_W(ADDR_W), .RESET_VAL(SP_RESET), .STEP(STEP)) u_sp (
        .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop),
        .sp(sp_out), .sp_dn(sp_dn)
    );

    xstack_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .kind(kind_q), .pc_save(pc_q), .sr_save(sr_q), .held(held_q),
        .rdata(mem_rdata), .word_a(word_a), .word_b(word_b),
        .pc_one(pc_one), .pc_two(pc_two), .sr_two(sr_two)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (kind_e'(req_kind))
                        K_SCALL:           state_d = ST_PUSH_B;
                        K_LCALL, K_IENTER: state_d = ST_PUSH_A;
                        default:           state_d = ST_POP_A;
                    endcase
                end
            end
            ST_PUSH_A: state_d = ST_PUSH_B;
            ST_PUSH_B: state_d = ST_FIN;
            ST_POP_A:  state_d = (kind_q == K_SRET) ? ST_FIN : ST_POP_B;
            ST_POP_B:  state_d = ST_FIN;
            ST_FIN:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = sp_out;
        mem_wdata = '0;
        unique case (state_q)
            ST_PUSH_A: begin
                mem_en = 1'b1; mem_we = 1'b1; mem_addr = sp_dn; mem_wdata = word_a;
            end
            ST_PUSH_B: begin
                mem_en = 1'b1; mem_we = 1'b1; mem_addr = sp_dn; mem_wdata = word_b;
            end
            ST_POP_A, ST_POP_B: mem_en = 1'b1;
            default: ;
        endcase
    end

    assign busy = (state_q != ST_IDLE);
    assign done = (state_q == ST_FIN);

    // frame data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= K_SCALL;
            pc_q   <= '0;
            sr_q   <= '0;
            vec_q  <= '0;
            held_q <= '0;
            pc_out <= '0;
            sr_out <= '0;
        end else begin
            if (accept) begin
                kind_q <= kind_e'(req_kind);
                pc_q   <= pc_in;
                sr_q   <= sr_in;
                vec_q  <= vec_in;
            end
            if (state_q == ST_POP_A) begin
                held_q <= mem_rdata;
                if (kind_q == K_SRET) pc_out <= pc_one;
            end
            if (state_q == ST_POP_B) begin
                pc_out <= pc_two;
                if (kind_q == K_IRET) sr_out <= sr_two;
            end
            if (state_q == ST_PUSH_B && kind_q == K_IENTER)
                pc_out <= {{HI_W{1'b0}}, vec_q};
        end
    end

    // a write moves the pointer onto the written address
    assert_push_sp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |=> (sp_out == $past(mem_addr)));

    // a read moves the pointer one word above the read address
    assert_pop_sp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> (sp_out == $past(mem_addr) + ADDR_W'(STEP)));

    // an idle cycle that accepts nothing keeps the pointer
    assert_idle_sp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (busy || $stable(sp_out)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_done_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
endmodule

// File: tb/tb_xstack_ctrl.sv
module tb_xstack_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [19:0] pc_in = '0;
    logic [11:0] sr_in = '0;
    logic [15:0] vec_in = '0;
    logic        busy, done, mem_en, mem_we;
    logic [19:0] pc_out, sp_out, mem_addr;
    logic [15:0] sr_out, mem_wdata, mem_rdata;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    logic [15:0] mem     [0:1023];
    logic [15:0] exp_mem [0:1023];
    logic [19:0] exp_sp = 20'h00400;
    logic [19:0] exp_pc = '0;
    logic [15:0] exp_sr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xstack_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .pc_in(pc_in), .sr_in(sr_in), .vec_in(vec_in), .busy(busy), .done(done),
        .pc_out(pc_out), .sr_out(sr_out), .sp_out(sp_out), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr[10:1]];
    always @(posedge clk) if (mem_en && mem_we) mem[mem_addr[10:1]] <= mem_wdata;

    function automatic int ix(input logic [19:0] a);
        return int'(a[10:1]);
    endfunction

    function automatic string tag(input logic [2:0] k);
        case (k)
            3'd0: return "R4";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic do_op(input logic [2:0] k, input logic [19:0] pc,
                         input logic [11:0] sr, input logic [15:0] vec, input bit poke);
        int n;
        int cnt;
        logic [19:0] a0, a1;
        logic [15:0] w0, w1;
        bit push;
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; pc_in = pc; sr_in = sr; vec_in = vec;
        push = (k <= 3'd2);
        a0 = '0; a1 = '0;
        case (k)
            3'd0: begin
                n = 1; exp_sp -= 20'd2; a0 = exp_sp; exp_mem[ix(a0)] = pc[15:0];
            end
            3'd1: begin
                n = 2; exp_sp -= 20'd2; a0 = exp_sp; exp_mem[ix(a0)] = {12'h000, pc[19:16]};
                exp_sp -= 20'd2; a1 = exp_sp; exp_mem[ix(a1)] = pc[15:0];
            end
            3'd2: begin
                n = 2; exp_sp -= 20'd2; a0 = exp_sp; exp_mem[ix(a0)] = pc[15:0];
                exp_sp -= 20'd2; a1 = exp_sp; exp_mem[ix(a1)] = {pc[19:16], sr};
                exp_pc = {4'h0, vec};
            end
            3'd3: begin
                n = 1; w0 = exp_mem[ix(exp_sp)]; exp_sp += 20'd2; exp_pc = {4'h0, w0};
            end
            3'd4: begin
                n = 2; w0 = exp_mem[ix(exp_sp)]; w1 = exp_mem[ix(exp_sp + 20'd2)];
                exp_sp += 20'd4; exp_pc = {w1[3:0], w0};
            end
            default: begin
                n = 2; w0 = exp_mem[ix(exp_sp)]; w1 = exp_mem[ix(exp_sp + 20'd2)];
                exp_sp += 20'd4; exp_pc = {w0[15:12], w1}; exp_sr = {4'h0, w0[11:0]};
            end
        endcase
        @(negedge clk);
        if (poke) begin
            req_kind = 3'd0; pc_in = 20'(~pc); sr_in = ~sr; vec_in = ~vec;
        end else req_valid = 1'b0;
        chk(busy === 1'b1, "R3", "busy after accept", 32'(busy), 32'd1);
        cnt = 1;
        while (done !== 1'b1 && cnt < 12) begin
            @(negedge clk);
            cnt++;
        end
        req_valid = 1'b0;
        chk(cnt == n + 1, "R3", "cycles to done", 32'(cnt), 32'(n + 1));
        chk(pc_out === exp_pc, (k <= 3'd1) ? "R10" : tag(k), "pc_out", 32'(pc_out), 32'(exp_pc));
        chk(sr_out === exp_sr, (k == 3'd5) ? "R9" : "R10", "sr_out", 32'(sr_out), 32'(exp_sr));
        chk(sp_out === exp_sp, "R3", "sp_out", 32'(sp_out), 32'(exp_sp));
        if (poke) chk(1'b1, "R2", "poke while busy", 0, 0);
        if (push) begin
            chk(mem[ix(a0)] === exp_mem[ix(a0)], tag(k), "first word",
                32'(mem[ix(a0)]), 32'(exp_mem[ix(a0)]));
            if (n == 2)
                chk(mem[ix(a1)] === exp_mem[ix(a1)], tag(k), "second word",
                    32'(mem[ix(a1)]), 32'(exp_mem[ix(a1)]));
        end
        @(negedge clk);
        chk(!busy && !done, "R11", "idle after done", {30'd0, busy, done}, 32'd0);
    endtask

    task automatic do_bad(input logic [2:0] k);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; pc_in = 20'hFFFFF;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!busy && !mem_en, "R2", "illegal code ignored", {30'd0, busy, mem_en}, 32'd0);
        chk(sp_out === exp_sp, "R2", "sp after illegal", 32'(sp_out), 32'(exp_sp));
    endtask

    initial begin
        void'($urandom(32'h5eed1234));
        for (int i = 0; i < 1024; i++) begin
            mem[i] = 16'($urandom);
            exp_mem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        chk(sp_out === 20'h00400 && !busy && !done && !mem_en && pc_out === '0 && sr_out === '0,
            "R1", "reset state", 32'(sp_out), 32'h00400);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sp_out === 20'h00400 && !busy, "R1", "after release", 32'(sp_out), 32'h00400);

        do_bad(3'd6);
        do_bad(3'd7);
        // R5 then R8 round trip with upper bits set
        do_op(3'd1, 20'hA1234, 12'h0, 16'h0, 1'b0);
        do_op(3'd4, 20'h0, 12'h0, 16'h0, 1'b0);
        chk(pc_out === 20'hA1234, "R8", "long round trip", 32'(pc_out), 32'hA1234);
        // R8 garbage in wasted bits
        do_op(3'd1, 20'h35678, 12'h0, 16'h0, 1'b0);
        mem[ix(exp_sp + 20'd2)] = 16'hABC7;
        exp_mem[ix(exp_sp + 20'd2)] = 16'hABC7;
        do_op(3'd4, 20'h0, 12'h0, 16'h0, 1'b0);
        chk(pc_out === 20'h75678, "R8", "wasted bits ignored", 32'(pc_out), 32'h75678);
        // R6 then R9 round trip, all savable status bits set
        do_op(3'd2, 20'hF0ACE, 12'hFFF, 16'hC000, 1'b0);
        chk(pc_out === 20'h0C000, "R6", "vector zero-extended", 32'(pc_out), 32'h0C000);
        do_op(3'd5, 20'h0, 12'h0, 16'h0, 1'b0);
        chk(pc_out === 20'hF0ACE && sr_out === 16'h0FFF, "R9", "int round trip",
            32'(pc_out), 32'hF0ACE);
        // R4 then R7: upper bits lost on a short frame
        do_op(3'd0, 20'h9BEEF, 12'h0, 16'h0, 1'b0);
        do_op(3'd3, 20'h0, 12'h0, 16'h0, 1'b0);
        chk(pc_out === 20'h0BEEF, "R7", "short return zero-extends", 32'(pc_out), 32'h0BEEF);
        // R2 request held during busy
        do_op(3'd2, 20'h51111, 12'h155, 16'h2222, 1'b1);
        do_op(3'd5, 20'h0, 12'h0, 16'h0, 1'b1);

        for (int i = 0; i < 300; i++) begin
            logic [2:0] k;
            k = 3'($urandom_range(0, 5));
            if (exp_sp < 20'h00100 && k <= 3'd2) k = k + 3'd3;
            if (exp_sp > 20'h00700 && k >= 3'd3) k = k - 3'd3;
            do_op(k, 20'($urandom), 12'($urandom), 16'($urandom), ($urandom_range(0, 7) == 0));
        end
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule